// File: doc/BRIEF.md
# Width-Matching FIFO Read Unpacker

This block sits between the read port of a 36-bit FIFO memory and an output port that may be 36, 18 or 9 bits wide. Each long word taken from memory is split into one, two or four pieces. The pieces leave through a 36-bit output register, one piece for each read request. In word and byte modes the piece sits in the low lanes, and all higher lanes are driven to zero. The pieces go out either most significant first or least significant first.

After a long word has been fetched, the pieces that are still owed are kept in an auxiliary register. Later read requests are served from that register. A new long word is taken from memory only after every piece of the previous one has been emitted. The memory presents its head word on `mem_data` and qualifies it with `mem_valid`. The block pops it by raising `mem_rd` in the same cycle as the request.

The bus width and the byte order are read from configuration pins while reset is asserted. They are frozen from the first clock edge at which reset is seen released.

Top module: `wm_read_unpacker`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_data` is zero and `mem_rd` is low while `rd_req` is low.
- R2: With `cfg_size` = 2'b00 (or the reserved value 2'b11), a read request that sees `mem_valid` high raises `mem_rd` in that cycle, and the whole 36-bit word appears on `out_data` after the next clock edge.
- R3: With `cfg_size` = 2'b01 and `cfg_big_endian` low, successive reads deliver bits [17:0] and then bits [35:18] of a long word in lanes [17:0], with lanes [35:18] at zero.
- R4: With `cfg_size` = 2'b01 and `cfg_big_endian` high, the order is bits [35:18] first and then bits [17:0], in lanes [17:0].
- R5: With `cfg_size` = 2'b10 and `cfg_big_endian` low, four reads deliver the bytes at bits [8:0], [17:9], [26:18] and [35:27] in that order, in lanes [8:0], with lanes [35:9] at zero.
- R6: With `cfg_size` = 2'b10 and `cfg_big_endian` high, the byte order is reversed: [35:27] comes first and [8:0] comes last.
- R7: `mem_rd` stays low while pieces of the current long word are still owed, even when `mem_valid` is high.
- R8: A read request with no piece owed and `mem_valid` low raises no `mem_rd` and leaves `out_data` unchanged. The next long word then starts again with its first piece.
- R9: In a cycle with `rd_req` low, `mem_rd` is low and `out_data` keeps its value after the next edge.
- R10: Changes to `cfg_size` or `cfg_big_endian` after reset is released have no effect on piece width or order until the next reset.
- R11: In long-word mode, `cfg_big_endian` has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; configuration is sampled while it is low |
| cfg_size | input | 2 | Port width: 00 long word, 01 word, 10 byte, 11 treated as long word |
| cfg_big_endian | input | 1 | 1: most significant piece first; 0: least significant first |
| rd_req | input | 1 | Request for one piece on the output register |
| mem_valid | input | 1 | Memory has a long word at its head |
| mem_data | input | 36 | Head long word of the memory |
| mem_rd | output | 1 | Pops the head long word at this clock edge |
| out_data | output | 36 | Output register; lanes above the active width are zero |

## Verification
The bench builds the block with its default piece width of 9 bits. This gives a 36-bit long word, so all three widths and both byte orders are reachable, including the reserved width code. A queue-based model predicts `mem_rd` before each edge and `out_data` after it. Request patterns mix idle cycles, empty-memory requests at long-word boundaries, and configuration pin changes after reset.

// File: rtl/wmu_pkg.sv
// Shared types for the width-matching read unpacker.
// Assumes a long word made of exactly four equal pieces.
package wmu_pkg;

    typedef enum logic [1:0] {
        BUS_LONG = 2'b00,
        BUS_WORD = 2'b01,
        BUS_BYTE = 2'b10
    } bus_size_e;

    // Map the pin code to a width; the reserved code falls back to long word.
    function automatic bus_size_e decode_size(input logic [1:0] code);
        case (code)
            2'b01:   return BUS_WORD;
            2'b10:   return BUS_BYTE;
            default: return BUS_LONG;
        endcase
    endfunction

    // Index of the final piece of a long word for a given width.
    function automatic logic [1:0] final_piece(input bus_size_e s);
        case (s)
            BUS_WORD: return 2'd1;
            BUS_BYTE: return 2'd3;
            default:  return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/wmu_cfg_latch.sv
// Holds the bus width and byte order.
// The pins are followed while reset is low and frozen once reset is released.
// Assumes the pins are settled before reset is released.
module wmu_cfg_latch
    import wmu_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic [1:0] size_pin,
    input  logic      big_pin,
    output bus_size_e size_q,
    output logic      big_q
);

    // Track the pins during reset, hold them afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= decode_size(size_pin);
            big_q  <= big_pin;
        end
    end

    // R10
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(size_q) && $stable(big_q)));

endmodule

// File: rtl/wmu_seq.sv
// Piece sequencer. It decides when a long word is fetched and which piece
// of it is emitted. pend_q marks that pieces are still owed from the
// auxiliary register, and idx_q is the next logical piece to emit.
module wmu_seq
    import wmu_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  bus_size_e size_q,
    input  logic      rd_req,
    input  logic      mem_valid,
    output logic      fetch,
    output logic      load_out,
    output logic      pend,
    output logic [1:0] sel_idx
);

    logic       pend_q;
    logic [1:0] idx_q;
    logic [1:0] last;
    logic       drain;

    // Decode fetch and drain conditions for this cycle.
    always_comb begin
        last     = final_piece(size_q);
        fetch    = rd_req && !pend_q && mem_valid;
        drain    = rd_req && pend_q;
        load_out = fetch || drain;
        pend     = pend_q;
        sel_idx  = pend_q ? idx_q : 2'd0;
    end

    // Advance the piece counter; it wraps at the width's last piece.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            idx_q  <= 2'd0;
        end else if (fetch) begin
            if (last != 2'd0) begin
                pend_q <= 1'b1;
                idx_q  <= 2'd1;
            end
        end else if (drain) begin
            if (idx_q == last) begin
                pend_q <= 1'b0;
                idx_q  <= 2'd0;
            end else begin
                idx_q <= idx_q + 2'd1;
            end
        end
    end

    // R7
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> (idx_q != 2'd0 && idx_q <= last));

    // R2
    long_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch && size_q == BUS_LONG) |=> !pend_q);

    // R3
    split_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch && size_q != BUS_LONG) |=> (pend_q && idx_q == 2'd1));

endmodule

// File: rtl/wmu_piece_sel.sv
// Combinational piece extractor. It picks logical piece idx of a long word
// for the given width and byte order and returns it zero-extended in the
// low lanes. Assumes a long word of four PIECE_W-bit bytes.
module wmu_piece_sel
    import wmu_pkg::*;
#(
    parameter int PIECE_W = 9,
    localparam int LW_W   = 4 * PIECE_W,
    localparam int WD_W   = 2 * PIECE_W
) (
    input  logic [LW_W-1:0] src,
    input  bus_size_e       size_q,
    input  logic            big_q,
    input  logic [1:0]      idx,
    output logic [LW_W-1:0] piece
);

    logic [PIECE_W-1:0] byte_a [4];
    logic [WD_W-1:0]    word_a [2];
    logic [1:0]         bidx;
    logic               widx;

    for (genvar g = 0; g < 4; g++) begin : g_bytes
        assign byte_a[g] = src[g*PIECE_W +: PIECE_W];
    end
    for (genvar g = 0; g < 2; g++) begin : g_words
        assign word_a[g] = src[g*WD_W +: WD_W];
    end

    // Map the logical piece to a physical lane and zero the unused lanes.
    always_comb begin
        bidx = big_q ? (2'd3 - idx) : idx;
        widx = big_q ? ~idx[0] : idx[0];
        case (size_q)
            BUS_WORD: piece = {{(LW_W-WD_W){1'b0}}, word_a[widx]};
            BUS_BYTE: piece = {{(LW_W-PIECE_W){1'b0}}, byte_a[bidx]};
            default:  piece = src;
        endcase
    end

endmodule

// File: rtl/wm_read_unpacker.sv
// Top level of the width-matching read unpacker. It joins the configuration
// latch, the sequencer and the piece extractor, and holds the auxiliary
// long-word register and the output register.
// Assumes the memory shows its head word with mem_valid and pops on mem_rd.
module wm_read_unpacker
    import wmu_pkg::*;
#(
    parameter int PIECE_W = 9,
    localparam int LW_W   = 4 * PIECE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      cfg_size,
    input  logic            cfg_big_endian,
    input  logic            rd_req,
    input  logic            mem_valid,
    input  logic [LW_W-1:0] mem_data,
    output logic            mem_rd,
    output logic [LW_W-1:0] out_data
);

    bus_size_e       size_q;
    logic            big_q;
    logic            fetch;
    logic            load_out;
    logic            pend;
    logic [1:0]      sel_idx;
    logic [LW_W-1:0] aux_q;
    logic [LW_W-1:0] src;
    logic [LW_W-1:0] piece;

    wmu_cfg_latch u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .size_pin (cfg_size),
        .big_pin  (cfg_big_endian),
        .size_q   (size_q),
        .big_q    (big_q)
    );

    wmu_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .size_q    (size_q),
        .rd_req    (rd_req),
        .mem_valid (mem_valid),
        .fetch     (fetch),
        .load_out  (load_out),
        .pend      (pend),
        .sel_idx   (sel_idx)
    );

    // Choose between the fresh memory word and the held long word.
    always_comb begin
        src    = pend ? aux_q : mem_data;
        mem_rd = fetch;
    end

    wmu_piece_sel #(.PIECE_W(PIECE_W)) u_sel (
        .src    (src),
        .size_q (size_q),
        .big_q  (big_q),
        .idx    (sel_idx),
        .piece  (piece)
    );

    // Keep the fetched long word for the pieces still owed.
    always_ff @(posedge clk) begin
        if (!rst_n)     aux_q <= '0;
        else if (fetch) aux_q <= mem_data;
    end

    // Update the output register once for each served request.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_data <= '0;
        else if (load_out) out_data <= piece;
    end

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(out_data));

    // R5
    byte_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size_q == BUS_BYTE) |-> (out_data[LW_W-1:PIECE_W] == '0));

    // R3
    word_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size_q == BUS_WORD) |-> (out_data[LW_W-1:2*PIECE_W] == '0));

    // R7
    aux_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && rd_req) |=> $stable(aux_q));

endmodule

// File: tb/sim_wm_read_unpacker.sv
module sim_wm_read_unpacker;

    localparam int PW = 9;
    localparam int LW = 4 * PW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_size = 2'b00;
    logic          cfg_big_endian = 1'b0;
    logic          rd_req = 1'b0;
    logic          mem_valid = 1'b0;
    logic [LW-1:0] mem_data = '0;
    logic          mem_rd;
    logic [LW-1:0] out_data;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit finished = 1'b0;

    logic [LW-1:0] mq[$];
    logic [LW-1:0] pq[$];
    logic [LW-1:0] exp_out;
    int            cur_n;
    bit            cur_be;

    wm_read_unpacker #(.PIECE_W(PW)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_size       (cfg_size),
        .cfg_big_endian (cfg_big_endian),
        .rd_req         (rd_req),
        .mem_valid      (mem_valid),
        .mem_data       (mem_data),
        .mem_rd         (mem_rd),
        .out_data       (out_data)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            mismatched++;
            $display("FAIL R1 watchdog: cycles=%0d expected below 150000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Split a long word into its pieces in emission order.
    task automatic split(input logic [LW-1:0] w);
        int wd = LW / cur_n;
        for (int k = 0; k < cur_n; k++) begin
            int pos = cur_be ? (cur_n - 1 - k) : k;
            logic [LW-1:0] v = (w >> (pos * wd)) & ((LW'(1) << wd) - LW'(1));
            if (cur_n == 1) v = w;
            pq.push_back(v);
        end
    endtask

    // One cycle: drive, check mem_rd, advance the model, check out_data.
    task automatic step(input bit req, input string tag);
        bit exp_rd;
        rd_req    = req;
        mem_valid = (mq.size() > 0);
        mem_data  = (mq.size() > 0) ? mq[0] : '0;
        #1;
        exp_rd = req && (pq.size() == 0) && (mq.size() > 0);
        check({tag, " mem_rd"}, LW'(mem_rd), LW'(exp_rd));
        if (req) begin
            if (pq.size() > 0) exp_out = pq.pop_front();
            else if (mq.size() > 0) begin
                split(mq.pop_front());
                exp_out = pq.pop_front();
            end
        end
        @(posedge clk);
        #1;
        check({tag, " out_data"}, out_data, exp_out);
    endtask

    task automatic do_reset(input logic [1:0] sz, input bit be);
        rd_req = 1'b0;
        rst_n = 1'b0;
        cfg_size = sz;
        cfg_big_endian = be;
        mq.delete();
        pq.delete();
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset out", out_data, '0);
        rst_n = 1'b1;
        cur_n = (sz == 2'b01) ? 2 : (sz == 2'b10) ? 4 : 1;
        cur_be = be;
        exp_out = '0;
        @(posedge clk);
        #1;
        check("R1 post-reset mem_rd", LW'(mem_rd), '0);
        check("R1 post-reset out", out_data, '0);
    endtask

    task automatic run_mode(input logic [1:0] sz, input bit be, input string tag);
        do_reset(sz, be);
        mq.push_back(36'h9_8765_4321);
        for (int i = 0; i < 5; i++) mq.push_back({$urandom, 4'($urandom)});
        for (int i = 0; i < 30; i++) begin
            if (i % 5 == 3) step(1'b0, "R9");
            else step(1'b1, tag);
            if (i % 5 == 2) step(1'b1, {tag, " R7"});
        end
        // Drain, then request from an empty memory at a long-word boundary.
        while (pq.size() > 0 || mq.size() > 0) step(1'b1, tag);
        step(1'b1, "R8 empty");
        step(1'b1, "R8 empty");
        mq.push_back(36'hA_5A5A_C3C3);
        mq.push_back(36'h1_2345_6789);
        for (int i = 0; i < 9; i++) step(1'b1, "R8 resume");
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1;
        run_mode(2'b00, 1'b0, "R2");
        run_mode(2'b00, 1'b1, "R11");
        run_mode(2'b11, 1'b1, "R2 reserved");
        run_mode(2'b01, 1'b0, "R3");
        run_mode(2'b01, 1'b1, "R4");
        run_mode(2'b10, 1'b0, "R5");
        run_mode(2'b10, 1'b1, "R6");
        // R10: pins move after reset; the latched width and order stay.
        do_reset(2'b01, 1'b1);
        mq.push_back(36'hF_0F0F_1E1E);
        step(1'b1, "R10");
        cfg_size = 2'b10;
        cfg_big_endian = 1'b0;
        mq.push_back(36'h3_3333_CCCC);
        mq.push_back(36'h7_1111_2222);
        for (int i = 0; i < 8; i++) step(1'b1, "R10");
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule